// File: doc/BRIEF.md
# Serial NAND Program and Erase Sequencer

This block runs the write side of a serial NAND flash on its own. A host hands it one request: either a page program or an erase that covers one or more blocks. The block then produces every SPI frame the flash expects. It first unlocks writes. It then sends the operation with its address and, for a program, the payload. After that it reads the status register repeatedly until the flash is no longer busy, and it checks the relevant failure bit. When the operation has failed or the flash never became idle, it locks writes again before it reports.

The request port uses a valid/ready handshake. Program payload bytes arrive on a separate byte stream with its own valid/ready pair. Completion is a single-cycle `done` pulse with a 2-bit result code. On a failure or a timeout, `fail_addr` gives the byte address of the page or block that failed. The serial side is a single-lane SPI master in mode 0. Its clock speed is set at run time by a divider input.

Top module: `snand_pe_seq`

## Requirements
- R1: Every erase step and every program begins with a write-unlock frame that holds exactly the single byte 0x06.
- R2: An erase frame carries four bytes: 0xD8, 0x00, row[15:8], row[7:0]. The row is `req_row` with its low `BLK_SHIFT` (6) bits forced to zero.
- R3: A program sends two frames. The first is a cache-load frame: 0x02, col[15:8], col[7:0], then `req_len` payload bytes in stream order. The second is an execute frame: 0x10, 0x00, row[15:8], row[7:0].
- R4: After an erase or execute frame, the block sends status frames of three bytes: 0x0F, 0xC0, then one byte that it reads back. It repeats these frames while bit 0 of the byte it reads is 1.
- R5: If `MAX_POLLS` (100) status reads in a row all return bit 0 set, the block sends a write-lock frame (the single byte 0x04). It then reports result 2'b10 (timeout), with `fail_addr` = row << 11.
- R6: A clear busy bit together with a set failure bit (bit 2 for erase, bit 3 for program) leads to a write-lock frame (0x04). The block then reports result 2'b01 (fail), with `fail_addr` = row << 11 of that page or block.
- R7: When an operation succeeds, the block sends no write-lock frame and reports result 2'b00 (ok).
- R8: An erase with `req_len` = N covers N blocks in consecutive order, each with its own unlock, erase and status sequence. It stops at the first block that fails.
- R9: `spi_cs_n` stays high for at least `CS_GAP` (2) clocks between frames, and `spi_sck` is low whenever `spi_cs_n` is high.
- R10: `req_ready` is low from the cycle after a request is accepted until `done`. The block ignores a request that is presented meanwhile. `done` is high for exactly one cycle.
- R11: Bytes go out MSB first in SPI mode 0, and each half period of `spi_sck` lasts `clk_div`+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | Length of an SCK half period, in clocks, minus one |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (block is idle) |
| req_erase | input | 1 | 1 = block erase, 0 = page program |
| req_row | input | 16 | Page row address; for an erase, any row inside the first block |
| req_col | input | 16 | Column at which the cache load starts |
| req_len | input | LEN_W | Payload bytes (program) or block count (erase) |
| wr_valid | input | 1 | Payload byte offered |
| wr_ready | output | 1 | Payload byte taken this cycle if valid |
| wr_data | input | 8 | Payload byte |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 ok, 01 fail, 10 timeout |
| fail_addr | output | ADDR_W | Byte address of the failing page or block |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The path that is hardest to reach is a multi-block erase that fails on a block in the middle of the range. At that point the address has already advanced and several full unlock, erase and poll sequences have run. The bench includes a flash model that decodes each frame. The model can be told the number of busy status reads to return and which block number, or which program execute, must report failure. The bench sets up a mid-range erase failure and a device that never leaves busy, and it compares every frame against its expected sequence.

// File: rtl/snand_pe_pkg.sv
package snand_pe_pkg;

    localparam int ROW_W = 16;
    localparam int COL_W = 16;

    localparam logic [7:0] CMD_WR_UNLOCK = 8'h06;
    localparam logic [7:0] CMD_WR_LOCK   = 8'h04;
    localparam logic [7:0] CMD_ERASE     = 8'hD8;
    localparam logic [7:0] CMD_LOAD      = 8'h02;
    localparam logic [7:0] CMD_EXEC      = 8'h10;
    localparam logic [7:0] CMD_GET_REG   = 8'h0F;
    localparam logic [7:0] REG_STATUS    = 8'hC0;

    localparam logic [7:0] STAT_BUSY_M   = 8'h01;
    localparam logic [7:0] STAT_EFAIL_M  = 8'h04;
    localparam logic [7:0] STAT_PFAIL_M  = 8'h08;

    localparam logic [1:0] RES_OK      = 2'b00;
    localparam logic [1:0] RES_FAIL    = 2'b01;
    localparam logic [1:0] RES_TIMEOUT = 2'b10;

    typedef enum logic [2:0] {
        FR_UNLOCK, FR_LOCK, FR_ERASE, FR_LOAD, FR_EXEC, FR_STAT
    } frame_e;

    typedef enum logic [1:0] {
        SQ_IDLE, SQ_GAP, SQ_XFER
    } seq_state_e;

endpackage

// File: rtl/snand_byte_shifter.sv
module snand_byte_shifter #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             start,
    input  logic [7:0]       tx,
    output logic             byte_done,
    output logic [7:0]       rx,
    output logic             sck,
    output logic             mosi,
    input  logic             miso
);

    typedef struct packed {
        logic             busy;
        logic             sck;
        logic [2:0]       bit_idx;
        logic [DIV_W-1:0] tmr;
        logic [7:0]       sh;
        logic [7:0]       rx;
        logic             done;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy    = 1'b1;
                d.sh      = tx;
                d.bit_idx = '0;
                d.tmr     = div;
                d.sck     = 1'b0;
            end
        end else if (q.tmr != '0) begin
            d.tmr = q.tmr - 1'b1;
        end else begin
            d.tmr = div;
            if (!q.sck) begin
                d.sck = 1'b1;
                d.rx  = {q.rx[6:0], miso};
            end else begin
                d.sck = 1'b0;
                if (q.bit_idx == 3'd7) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.bit_idx = q.bit_idx + 3'd1;
                    d.sh      = {q.sh[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_done = q.done;
    assign rx        = q.rx;
    assign sck       = q.sck;
    assign mosi      = q.sh[7];

endmodule

// File: rtl/snand_frame_mux.sv
module snand_frame_mux
    import snand_pe_pkg::*;
#(
    parameter int LEN_W = 12,
    localparam int IDX_W = LEN_W + 2
) (
    input  frame_e           kind,
    input  logic [IDX_W-1:0] idx,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic [LEN_W-1:0] len,
    input  logic [7:0]       pay,
    output logic [7:0]       byte_out,
    output logic [IDX_W-1:0] last_idx,
    output logic             is_pay
);

    always_comb begin
        byte_out = 8'h00;
        last_idx = '0;
        is_pay   = 1'b0;
        unique case (kind)
            FR_UNLOCK: byte_out = CMD_WR_UNLOCK;
            FR_LOCK:   byte_out = CMD_WR_LOCK;
            FR_ERASE, FR_EXEC: begin
                last_idx = IDX_W'(3);
                unique case (idx)
                    IDX_W'(0): byte_out = (kind == FR_ERASE) ? CMD_ERASE : CMD_EXEC;
                    IDX_W'(2): byte_out = row[15:8];
                    IDX_W'(3): byte_out = row[7:0];
                    default:   byte_out = 8'h00;
                endcase
            end
            FR_STAT: begin
                last_idx = IDX_W'(2);
                unique case (idx)
                    IDX_W'(0): byte_out = CMD_GET_REG;
                    IDX_W'(1): byte_out = REG_STATUS;
                    default:   byte_out = 8'h00;
                endcase
            end
            FR_LOAD: begin
                last_idx = IDX_W'(len) + IDX_W'(2);
                is_pay   = (idx >= IDX_W'(3));
                unique case (idx)
                    IDX_W'(0): byte_out = CMD_LOAD;
                    IDX_W'(1): byte_out = col[15:8];
                    IDX_W'(2): byte_out = col[7:0];
                    default:   byte_out = pay;
                endcase
            end
            default: byte_out = 8'h00;
        endcase
    end

endmodule

// File: rtl/snand_pe_seq.sv
module snand_pe_seq
    import snand_pe_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int LEN_W      = 12,
    parameter int MAX_POLLS  = 100,
    parameter int CS_GAP     = 2,
    parameter int BLK_SHIFT  = 6,
    parameter int PAGE_SHIFT = 11,
    localparam int ADDR_W = ROW_W + PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_erase,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              done,
    output logic [1:0]        result,
    output logic [ADDR_W-1:0] fail_addr,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    localparam int IDX_W  = LEN_W + 2;
    localparam int POLL_W = $clog2(MAX_POLLS + 1);
    localparam int GAP_W  = $clog2(CS_GAP + 1);
    localparam logic [ROW_W-1:0] BLK_STEP = ROW_W'(1) << BLK_SHIFT;
    localparam logic [ROW_W-1:0] ROW_MASK = ~(BLK_STEP - 1'b1);

    typedef struct packed {
        seq_state_e        st;
        frame_e            kind;
        logic              erase;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  left;
        logic [POLL_W-1:0] polls;
        logic [IDX_W-1:0]  idx;
        logic [GAP_W-1:0]  gap;
        logic              inflight;
        logic              finish;
        logic              cs_n;
        logic              done;
        logic [1:0]        res;
        logic [ADDR_W-1:0] fail_addr;
    } seq_t;

    seq_t q, d;

    logic             eng_start, eng_done;
    logic [7:0]       eng_rx, fm_byte;
    logic [IDX_W-1:0] fm_last;
    logic             fm_pay;

    snand_frame_mux #(.LEN_W(LEN_W)) u_mux (
        .kind(q.kind), .idx(q.idx), .row(q.row), .col(q.col), .len(q.len),
        .pay(wr_data), .byte_out(fm_byte), .last_idx(fm_last), .is_pay(fm_pay)
    );

    snand_byte_shifter #(.DIV_W(DIV_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .div(clk_div), .start(eng_start), .tx(fm_byte),
        .byte_done(eng_done), .rx(eng_rx), .sck(spi_sck), .mosi(spi_mosi),
        .miso(spi_miso)
    );

    logic stat_busy, stat_fail;
    assign stat_busy = (eng_rx & STAT_BUSY_M) != 8'h00;
    assign stat_fail = (eng_rx & (q.erase ? STAT_EFAIL_M : STAT_PFAIL_M)) != 8'h00;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        eng_start = 1'b0;
        wr_ready  = 1'b0;
        unique case (q.st)
            SQ_IDLE: begin
                if (req_valid) begin
                    d.erase  = req_erase;
                    d.row    = req_erase ? (req_row & ROW_MASK) : req_row;
                    d.col    = req_col;
                    d.len    = req_len;
                    d.left   = req_len;
                    d.kind   = FR_UNLOCK;
                    d.gap    = '0;
                    d.finish = 1'b0;
                    d.res    = RES_OK;
                    d.st     = SQ_GAP;
                end
            end
            SQ_GAP: begin
                if (q.gap == GAP_W'(CS_GAP - 1)) begin
                    if (q.finish) begin
                        d.done = 1'b1;
                        d.st   = SQ_IDLE;
                    end else begin
                        d.st   = SQ_XFER;
                        d.cs_n = 1'b0;
                        d.idx  = '0;
                    end
                end else begin
                    d.gap = q.gap + 1'b1;
                end
            end
            SQ_XFER: begin
                if (!q.inflight) begin
                    if (fm_pay) begin
                        wr_ready = 1'b1;
                        if (wr_valid) begin
                            eng_start  = 1'b1;
                            d.inflight = 1'b1;
                        end
                    end else begin
                        eng_start  = 1'b1;
                        d.inflight = 1'b1;
                    end
                end else if (eng_done) begin
                    d.inflight = 1'b0;
                    if (q.idx != fm_last) begin
                        d.idx = q.idx + 1'b1;
                    end else begin
                        d.cs_n = 1'b1;
                        d.gap  = '0;
                        d.st   = SQ_GAP;
                        unique case (q.kind)
                            FR_UNLOCK: d.kind = q.erase ? FR_ERASE : FR_LOAD;
                            FR_LOAD:   d.kind = FR_EXEC;
                            FR_ERASE, FR_EXEC: begin
                                d.kind  = FR_STAT;
                                d.polls = '0;
                            end
                            FR_STAT: begin
                                d.polls = q.polls + 1'b1;
                                if (stat_busy) begin
                                    if (q.polls == POLL_W'(MAX_POLLS - 1)) begin
                                        d.res       = RES_TIMEOUT;
                                        d.fail_addr = {q.row, PAGE_SHIFT'(0)};
                                        d.kind      = FR_LOCK;
                                    end
                                end else if (stat_fail) begin
                                    d.res       = RES_FAIL;
                                    d.fail_addr = {q.row, PAGE_SHIFT'(0)};
                                    d.kind      = FR_LOCK;
                                end else if (q.erase && q.left > LEN_W'(1)) begin
                                    d.left = q.left - 1'b1;
                                    d.row  = q.row + BLK_STEP;
                                    d.kind = FR_UNLOCK;
                                end else begin
                                    d.finish = 1'b1;
                                end
                            end
                            default: d.finish = 1'b1;
                        endcase
                    end
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == SQ_IDLE);
    assign done      = q.done;
    assign result    = q.res;
    assign fail_addr = q.fail_addr;
    assign spi_cs_n  = q.cs_n;

endmodule

// File: rtl/snand_pe_seq_chk.sv
module snand_pe_seq_chk #(
    parameter int CS_GAP = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sck,
    input logic       req_valid,
    input logic       req_ready,
    input logic       done,
    input logic [1:0] result
);

    logic [7:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              hi_cnt <= '0;
        else if (!cs_n)          hi_cnt <= '0;
        else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 8'd1;
    end

    // R9: minimum deselect time before each frame
    assert_cs_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= 8'(CS_GAP)));

    // R9: serial clock idles low while deselected
    assert_sck_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    // R10: ready drops after acceptance
    assert_ready_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10: never ready while a frame is on the wire
    assert_no_ready_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !req_ready);

    // R10: completion is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: result code is one of the three defined values
    assert_result_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 2'b11));

endmodule

bind snand_pe_seq snand_pe_seq_chk #(.CS_GAP(CS_GAP)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck),
    .req_valid(req_valid), .req_ready(req_ready), .done(done), .result(result)
);

// File: tb/sim_snand_pe_seq.sv
module sim_snand_pe_seq;

    localparam int LEN_W  = 12;
    localparam int ADDR_W = 27;

    typedef struct packed {
        logic [7:0]   len;
        logic [127:0] data;
    } frame_t;

    typedef struct packed {
        logic [1:0]        res;
        logic [ADDR_W-1:0] addr;
    } res_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] clk_div = 8'd1;
    logic req_valid = 1'b0, req_ready, req_erase = 1'b0;
    logic [15:0] req_row = '0, req_col = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic wr_valid = 1'b0, wr_ready;
    logic [7:0] wr_data = '0;
    logic done;
    logic [1:0] result;
    logic [ADDR_W-1:0] fail_addr;
    logic spi_sck, spi_cs_n, spi_mosi, spi_miso;

    always #10 clk = ~clk;

    snand_pe_seq u0 (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .req_valid(req_valid),
        .req_ready(req_ready), .req_erase(req_erase), .req_row(req_row),
        .req_col(req_col), .req_len(req_len), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_data(wr_data), .done(done), .result(result),
        .fail_addr(fail_addr), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_tests = 0;
    int n_fail  = 0;

    frame_t   exp_fr_q[$];
    res_t     exp_res_q[$];
    logic [7:0] pay_q[$];

    // ---------------- flash model ----------------
    int         busy_cfg = 0;
    int         fail_blk_cfg = -1;
    logic       prog_fail_cfg = 1'b0;
    int         busy_left = 0;
    logic       fail_now = 1'b0;
    logic [7:0] fail_code = 8'h00;
    logic [7:0] m_stat = 8'h00;
    logic [127:0] m_data = '0;
    logic [7:0] m_sh = '0;
    int         m_n = 0, m_bits = 0;
    logic       m_active = 1'b0;
    int         min_gap = 1000, gap_cnt = 0;
    int         hi_cnt = 0, last_hi = 0;

    assign spi_miso = (m_n == 2) ? m_stat[3'(7 - m_bits)] : 1'b0;

    always @(negedge spi_cs_n) begin
        m_active = 1'b1;
        m_n = 0; m_bits = 0; m_data = '0;
        m_stat = (busy_left > 0) ? 8'h01 : (fail_now ? fail_code : 8'h00);
    end

    always @(posedge spi_sck) begin
        m_sh = {m_sh[6:0], spi_mosi};
        m_bits++;
        if (m_bits == 8) begin
            if (m_n < 16) m_data[m_n*8 +: 8] = m_sh;
            m_n++;
            m_bits = 0;
        end
    end

    // monitor: frames popped and compared as they complete
    always @(posedge spi_cs_n) begin
        if (m_active) begin
            frame_t e;
            m_active = 1'b0;
            n_tests++;
            if (exp_fr_q.size() == 0) begin
                n_fail++;
                $display("FAIL R10 unexpected frame: got len=%0d data=%h expected none",
                         m_n, m_data);
            end else begin
                e = exp_fr_q.pop_front();
                if (e.len != 8'(m_n) || e.data != m_data) begin
                    n_fail++;
                    $display("FAIL R1-frame check (R2 R3 R4 R5 R6): got len=%0d data=%h expected len=%0d data=%h",
                             m_n, m_data, e.len, e.data);
                end
            end
            case (m_data[7:0])
                8'hD8: begin
                    busy_left = busy_cfg;
                    fail_code = 8'h04;
                    fail_now  = (int'({m_data[23:16], m_data[31:24]} >> 6) == fail_blk_cfg);
                end
                8'h10: begin
                    busy_left = busy_cfg;
                    fail_code = 8'h08;
                    fail_now  = prog_fail_cfg;
                end
                8'h0F: if (busy_left > 0) busy_left--;
                default: ;
            endcase
        end
    end

    // gap and sck high-width measurement
    always @(posedge clk) begin
        if (spi_cs_n) gap_cnt++;
        else begin
            if (gap_cnt > 0 && gap_cnt < min_gap) min_gap = gap_cnt;
            gap_cnt = 0;
        end
        if (spi_sck) hi_cnt++;
        else if (hi_cnt != 0) begin
            last_hi = hi_cnt;
            hi_cnt = 0;
        end
    end

    // payload feeder
    logic pay_fire = 1'b0;
    always @(posedge clk) pay_fire = wr_valid && wr_ready;
    always @(negedge clk) begin
        if (pay_fire && pay_q.size() != 0) void'(pay_q.pop_front());
        pay_fire = 1'b0;
        wr_valid = (pay_q.size() != 0);
        wr_data  = (pay_q.size() != 0) ? pay_q[0] : 8'h00;
    end

    // result monitor
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n && prev_done && done) begin
            n_tests++; n_fail++;
            $display("FAIL R10 done high two cycles: got 1 expected 0");
        end
        if (rst_n && done) begin
            res_t e;
            n_tests++;
            if (exp_res_q.size() == 0) begin
                n_fail++;
                $display("FAIL R10 unexpected done: got result=%0d expected none", result);
            end else begin
                e = exp_res_q.pop_front();
                if (result != e.res || (e.res != 2'b00 && fail_addr != e.addr)) begin
                    n_fail++;
                    $display("FAIL R5/R6/R7 result: got res=%0d addr=%h expected res=%0d addr=%h",
                             result, fail_addr, e.res, e.addr);
                end
            end
        end
        prev_done = done;
    end

    // ---------------- driver helpers ----------------
    task automatic push_fr(input int n, input logic [127:0] d);
        exp_fr_q.push_back('{len: 8'(n), data: d});
    endtask

    task automatic exp_unlock(); push_fr(1, 128'h06); endtask
    task automatic exp_lock();   push_fr(1, 128'h04); endtask

    task automatic exp_rowcmd(input logic [7:0] op, input logic [15:0] row);
        logic [127:0] d = '0;
        d[7:0] = op; d[23:16] = row[15:8]; d[31:24] = row[7:0];
        push_fr(4, d);
    endtask

    task automatic exp_stat(input int times);
        for (int i = 0; i < times; i++) push_fr(3, 128'h00C00F);
    endtask

    task automatic exp_res(input logic [1:0] r, input logic [15:0] row);
        exp_res_q.push_back('{res: r, addr: {row, 11'b0}});
    endtask

    task automatic issue(input logic erase, input logic [15:0] row,
                         input logic [15:0] col, input int len);
        while (!req_ready) @(negedge clk);
        req_erase = erase; req_row = row; req_col = col; req_len = LEN_W'(len);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_all();
        while (exp_res_q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic check(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R10 watchdog expired: got hang expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset cs_n", int'(spi_cs_n), 1);
        check("R9 reset sck", int'(spi_sck), 0);
        check("R10 reset req_ready", int'(req_ready), 1);
        check("R10 reset done", int'(done), 0);

        // T1 R1 R2 R4 R7 R11: single erase, row low bits masked, two busy polls
        busy_cfg = 2;
        exp_unlock();
        exp_rowcmd(8'hD8, 16'h0A40);
        exp_stat(3);
        exp_res(2'b00, 16'h0A40);
        issue(1'b1, 16'h0A7F, 16'h0000, 1);
        wait_all();
        check("R11 sck half period div=1", last_hi, 2);

        // T2 R3 R11: program with payload, slower clock
        clk_div = 8'd2;
        busy_cfg = 1;
        begin
            logic [127:0] d = '0;
            d[7:0] = 8'h02; d[15:8] = 8'h02; d[23:16] = 8'h03;
            for (int i = 0; i < 5; i++) begin
                d[(3+i)*8 +: 8] = 8'hA0 + 8'(i * 7);
                pay_q.push_back(8'hA0 + 8'(i * 7));
            end
            exp_unlock();
            push_fr(8, d);
        end
        exp_rowcmd(8'h10, 16'h1234);
        exp_stat(2);
        exp_res(2'b00, 16'h1234);
        issue(1'b0, 16'h1234, 16'h0203, 5);
        wait_all();
        check("R11 sck half period div=2", last_hi, 3);
        check("R3 payload fully consumed", pay_q.size(), 0);
        clk_div = 8'd1;

        // T3 R6: program fail bit 3 -> lock frame, fail result
        busy_cfg = 0;
        prog_fail_cfg = 1'b1;
        pay_q.push_back(8'h5A);
        exp_unlock();
        push_fr(4, 128'h5A_BC_00_02 | 128'h0);
        exp_rowcmd(8'h10, 16'h0ABC);
        exp_stat(1);
        exp_lock();
        exp_res(2'b01, 16'h0ABC);
        issue(1'b0, 16'h0ABC, 16'h00BC, 1);
        wait_all();
        prog_fail_cfg = 1'b0;

        // T4 R8 R6: three-block erase failing on second block (block 6)
        fail_blk_cfg = 6;
        exp_unlock(); exp_rowcmd(8'hD8, 16'h0140); exp_stat(1);
        exp_unlock(); exp_rowcmd(8'hD8, 16'h0180); exp_stat(1);
        exp_lock();
        exp_res(2'b01, 16'h0180);
        issue(1'b1, 16'h0140, 16'h0000, 3);
        wait_all();
        fail_blk_cfg = -1;

        // T5 R8 R7: two-block erase all good, no lock frame
        exp_unlock(); exp_rowcmd(8'hD8, 16'h0200); exp_stat(1);
        exp_unlock(); exp_rowcmd(8'hD8, 16'h0240); exp_stat(1);
        exp_res(2'b00, 16'h0200);
        issue(1'b1, 16'h0201, 16'h0000, 2);
        wait_all();

        // T6 R5 R10: device stuck busy, and a request offered mid-operation
        busy_cfg = 1000;
        exp_unlock(); exp_rowcmd(8'hD8, 16'h0040); exp_stat(100);
        exp_lock();
        exp_res(2'b10, 16'h0040);
        issue(1'b1, 16'h0040, 16'h0000, 1);
        repeat (300) @(negedge clk);
        begin
            int seen_ready = 0;
            req_erase = 1'b0; req_row = 16'h7777; req_len = LEN_W'(1);
            req_valid = 1'b1;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (req_ready) seen_ready++;
            end
            req_valid = 1'b0;
            check("R10 req_ready low while busy", seen_ready, 0);
        end
        wait_all();
        busy_cfg = 0;

        check("R9 minimum deselect gap ok", int'(min_gap >= 2), 1);
        check("R10 no leftover expected frames", exp_fr_q.size(), 0);
        check("R10 idle after all operations", int'(req_ready), 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule